// File: doc/BRIEF.md
# Slow-Clock System Timer with Alarm and Periodic Tick

This block is a system timer that sits on a plain register bus and runs from a single bus clock. A one-cycle enable pulse, `slow_tick`, marks each period of a 32,768 Hz slow clock. Three engines count these pulses. A 20-bit real-time counter advances once every P pulses, where P is a programmable prescale value. An alarm comparator holds an absolute counter value and fires when the counter steps onto it. A periodic engine raises an event every N pulses and does not depend on the prescaler.

Each engine event sets a sticky flag in a status register. A read of the status register clears the flags. An interrupt mask is set through one register and cleared through another, and both use the same bit positions as the status register. A single `irq` output is high while any flag is set and its mask bit is enabled. An external pulse sets a watchdog-overflow flag.

The bus takes one access per cycle and never stalls, so requests have no back-pressure. A read returns its data one cycle later, marked by `bus_rvalid`. A new read may be issued every cycle.

Top module: `sys_timer_top`

## Requirements
- R1: After reset the counter reads 0, the prescale register (offset 0x00) reads 32768, and the periodic register (0x04), status (0x08), mask (0x14) and alarm (0x18) all read 0. `irq` is low.
- R2: The counter (0x1C) advances by one each time P slow ticks have been counted, where P is the value in 0x00. A value of 1 advances it on every tick and a value of 0 means 65536 ticks. Writing 0x00 restarts the tick count from zero without changing the counter.
- R3: The counter is CNT_W bits wide (20 by default) and wraps from its all-ones value to 0.
- R4: Status bit 3 (alarm) sets when the counter steps onto the value held in the alarm register (0x18). Writing the alarm register with the value the counter already holds raises no event until the counter has wrapped back to that value.
- R5: Status bit 0 (periodic) sets once every N slow ticks, where N is the value in 0x04. A value of 0 stops the periodic engine, and writing 0x04 restarts its count.
- R6: Status bit 2 (counter step) sets on every counter increment.
- R7: Status bit 1 (watchdog overflow) sets when `wd_ovf_set` is pulsed.
- R8: A read of 0x08 returns the pending flags and clears them. A flag that sets in the same cycle as that read stays pending and does not appear in the returned value. Flags are otherwise sticky.
- R9: Writing ones to 0x0C sets those mask bits, and writing ones to 0x10 clears them. Zero bits in either write leave the mask unchanged. The mask reads back at 0x14.
- R10: `irq` is high exactly when some status flag and its mask bit are both set.
- R11: Writes to the read-only registers 0x14 and 0x1C change nothing.
- R12: Without `slow_tick` pulses the counter and the periodic engine hold their state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slow_tick | input | 1 | One-cycle enable pulse for each slow-clock period |
| wd_ovf_set | input | 1 | Pulse that sets the watchdog-overflow flag |
| bus_sel | input | 1 | Access request for this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | High the cycle after a read was accepted |
| irq | output | 1 | Level interrupt |

## Verification
Two events can land on the same clock edge: the status read that clears the flags, and a new flag being set. The bench pulses `wd_ovf_set` in the same cycle as a status read. It expects that read to return zero, `irq` to stay high, and the next status read to show the watchdog bit. The alarm is provoked in a second way: the alarm register is written with the live count, and the bench then runs exactly one tick short of a full wrap and then one tick more. The alarm bit must be absent before that last tick and present after it.

// File: rtl/st_pkg.sv
package st_pkg;
  localparam int NFLG    = 4;
  localparam int FLG_PIT = 0;
  localparam int FLG_WDG = 1;
  localparam int FLG_INC = 2;
  localparam int FLG_ALM = 3;

  localparam logic [4:0] A_PRE  = 5'h00;
  localparam logic [4:0] A_PER  = 5'h04;
  localparam logic [4:0] A_STAT = 5'h08;
  localparam logic [4:0] A_EN   = 5'h0C;
  localparam logic [4:0] A_DIS  = 5'h10;
  localparam logic [4:0] A_MASK = 5'h14;
  localparam logic [4:0] A_ALM  = 5'h18;
  localparam logic [4:0] A_CNT  = 5'h1C;
endpackage

// File: rtl/st_rtc.sv
module st_rtc #(
  parameter int CNT_W   = 20,
  parameter int PRE_W   = 16,
  parameter int PRE_RST = 32768
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_tick,
  input  logic             pre_wr,
  input  logic             alm_wr,
  input  logic [PRE_W-1:0] pre_wdata,
  input  logic [CNT_W-1:0] alm_wdata,
  output logic [PRE_W-1:0] pre_q,
  output logic [CNT_W-1:0] alm_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             inc_evt,
  output logic             alm_evt
);
  localparam int LIM_W = PRE_W + 1;

  logic [PRE_W-1:0] div_q;
  logic [LIM_W-1:0] limit;
  logic             div_last;
  logic [CNT_W-1:0] cnt_nxt;

  // zero selects the longest period, 2^PRE_W ticks
  assign limit    = (pre_q == '0) ? (LIM_W'(1) << PRE_W) : LIM_W'(pre_q);
  assign div_last = (LIM_W'(div_q) == limit - LIM_W'(1));
  assign inc_evt  = slow_tick && div_last && !pre_wr;
  assign cnt_nxt  = cnt_q + CNT_W'(1);
  assign alm_evt  = inc_evt && (cnt_nxt == alm_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= PRE_W'(PRE_RST);
      div_q <= '0;
      cnt_q <= '0;
      alm_q <= '0;
    end else begin
      if (pre_wr) begin
        pre_q <= pre_wdata;
        div_q <= '0;
      end else if (slow_tick) begin
        div_q <= div_last ? '0 : div_q + PRE_W'(1);
      end
      if (inc_evt) cnt_q <= cnt_nxt;
      if (alm_wr)  alm_q <= alm_wdata;
    end
  end

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  assert_alarm_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_evt && !alm_wr) |=> (cnt_q == alm_q));
endmodule

// File: rtl/st_pit.sv
module st_pit #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_tick,
  input  logic             per_wr,
  input  logic [PER_W-1:0] per_wdata,
  output logic [PER_W-1:0] per_q,
  output logic             pit_evt
);
  logic [PER_W-1:0] ph_q;
  logic             run;
  logic             ph_last;

  assign run     = (per_q != '0);
  assign ph_last = (ph_q == per_q - PER_W'(1));
  assign pit_evt = slow_tick && run && ph_last && !per_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= '0;
      ph_q  <= '0;
    end else if (per_wr) begin
      per_q <= per_wdata;
      ph_q  <= '0;
    end else if (slow_tick && run) begin
      ph_q <= ph_last ? '0 : ph_q + PER_W'(1);
    end
  end

  assert_pit_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pit_evt && per_q != PER_W'(1)) |=> !pit_evt);
endmodule

// File: rtl/st_irq.sv
module st_irq #(
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_vec,
  input  logic          rd_clr,
  input  logic          en_wr,
  input  logic          dis_wr,
  input  logic [NF-1:0] wbits,
  output logic [NF-1:0] flags_q,
  output logic [NF-1:0] mask_q,
  output logic          irq
);
  assign irq = |(flags_q & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      mask_q  <= '0;
    end else begin
      flags_q <= (rd_clr ? '0 : flags_q) | set_vec;
      if (en_wr)       mask_q <= mask_q | wbits;
      else if (dis_wr) mask_q <= mask_q & ~wbits;
    end
  end

  assert_clear_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |=> (flags_q == $past(set_vec)));

  assert_flags_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  assert_mask_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> ((mask_q & $past(wbits)) == $past(wbits)));

  assert_mask_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_wr && !en_wr) |=> ((mask_q & $past(wbits)) == '0));
endmodule

// File: rtl/sys_timer_top.sv
module sys_timer_top #(
  parameter int CNT_W   = 20,
  parameter int PRE_W   = 16,
  parameter int PRE_RST = 32768,
  parameter int PER_W   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slow_tick,
  input  logic        wd_ovf_set,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_rvalid,
  output logic        irq
);
  import st_pkg::*;

  logic             wr_pre, wr_per, wr_en, wr_dis, wr_alm, rd_any, rd_stat;
  logic [PRE_W-1:0] pre_q;
  logic [PER_W-1:0] per_q;
  logic [CNT_W-1:0] alm_q, cnt_q;
  logic             inc_evt, alm_evt, pit_evt;
  logic [NFLG-1:0]  set_vec, flags_q, mask_q;
  logic [31:0]      rd_mux;
  logic             wdata_unused;

  assign wdata_unused = &{1'b0, bus_wdata};

  assign wr_pre  = bus_sel && bus_wr && (bus_addr == A_PRE);
  assign wr_per  = bus_sel && bus_wr && (bus_addr == A_PER);
  assign wr_en   = bus_sel && bus_wr && (bus_addr == A_EN);
  assign wr_dis  = bus_sel && bus_wr && (bus_addr == A_DIS);
  assign wr_alm  = bus_sel && bus_wr && (bus_addr == A_ALM);
  assign rd_any  = bus_sel && !bus_wr;
  assign rd_stat = rd_any && (bus_addr == A_STAT);

  st_rtc #(.CNT_W(CNT_W), .PRE_W(PRE_W), .PRE_RST(PRE_RST)) u_rtc (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
    .pre_wr(wr_pre), .alm_wr(wr_alm),
    .pre_wdata(bus_wdata[PRE_W-1:0]), .alm_wdata(bus_wdata[CNT_W-1:0]),
    .pre_q(pre_q), .alm_q(alm_q), .cnt_q(cnt_q),
    .inc_evt(inc_evt), .alm_evt(alm_evt)
  );

  st_pit #(.PER_W(PER_W)) u_pit (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
    .per_wr(wr_per), .per_wdata(bus_wdata[PER_W-1:0]),
    .per_q(per_q), .pit_evt(pit_evt)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[FLG_PIT] = pit_evt;
    set_vec[FLG_WDG] = wd_ovf_set;
    set_vec[FLG_INC] = inc_evt;
    set_vec[FLG_ALM] = alm_evt;
  end

  st_irq #(.NF(NFLG)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .rd_clr(rd_stat),
    .en_wr(wr_en), .dis_wr(wr_dis), .wbits(bus_wdata[NFLG-1:0]),
    .flags_q(flags_q), .mask_q(mask_q), .irq(irq)
  );

  always_comb begin
    unique case (bus_addr)
      A_PRE:   rd_mux = 32'(pre_q);
      A_PER:   rd_mux = 32'(per_q);
      A_STAT:  rd_mux = 32'(flags_q);
      A_MASK:  rd_mux = 32'(mask_q);
      A_ALM:   rd_mux = 32'(alm_q);
      A_CNT:   rd_mux = 32'(cnt_q);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_any;
      if (rd_any) bus_rdata <= rd_mux;
    end
  end

  assert_irq_needs_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);

  assert_rvalid_follows_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_any |=> bus_rvalid);
endmodule

// File: tb/tb_sys_timer_top.sv
module tb_sys_timer_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0;
  logic        wd_ovf_set = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { logic [31:0] val; string tag; } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sys_timer_top #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wd_ovf_set(wd_ovf_set),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq(irq)
  );

  // monitor: pop one expected item for every read response
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL unexpected response actual %h expected none", bus_rdata);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (bus_rdata !== e.val) begin
          errors++;
          $display("FAIL %s actual %h expected %h", e.tag, bus_rdata, e.val);
        end
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
    exp_t x;
    x.val = e; x.tag = tag;
    sb.push_back(x);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic tick(input int n);
    slow_tick = 1;
    repeat (n) @(negedge clk);
    slow_tick = 0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s irq actual %b expected %b", tag, irq, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values
    chk_irq(1'b0, "R1");
    rd(5'h00, 32'd32768, "R1 prescale");
    rd(5'h04, 0, "R1 periodic");
    rd(5'h08, 0, "R1 status");
    rd(5'h14, 0, "R1 mask");
    rd(5'h18, 0, "R1 alarm");
    rd(5'h1C, 0, "R1 counter");
    // R2, R6: prescale 1
    wr(5'h00, 1);
    tick(5);
    rd(5'h1C, 5, "R2 prescale one");
    rd(5'h08, 32'h4, "R6 step flag");
    rd(5'h08, 0, "R8 cleared");
    // R2 prescale 3 and restart on write
    wr(5'h00, 3);
    tick(2);
    rd(5'h1C, 5, "R2 prescale three early");
    tick(1);
    rd(5'h1C, 6, "R2 prescale three step");
    tick(2);
    wr(5'h00, 3);
    tick(2);
    rd(5'h1C, 6, "R2 restart after write");
    tick(1);
    rd(5'h1C, 7, "R2 restart step");
    // R2 zero means 65536
    wr(5'h00, 0);
    tick(65535);
    rd(5'h1C, 7, "R2 zero early");
    tick(1);
    rd(5'h1C, 8, "R2 zero step");
    // R4 alarm
    wr(5'h00, 1);
    rd(5'h08, 32'h4, "R6 step flags");
    wr(5'h18, 11);
    tick(2);
    rd(5'h08, 32'h4, "R4 before target");
    tick(1);
    rd(5'h08, 32'hC, "R4 alarm hit");
    rd(5'h18, 11, "R4 alarm readback");
    // R4 / R3 writing current count cancels until wrap
    wr(5'h18, 11);
    tick((1 << CW) - 1);
    rd(5'h1C, 10, "R3 wrapped count");
    rd(5'h08, 32'h4, "R4 no alarm before wrap");
    tick(1);
    rd(5'h08, 32'hC, "R4 alarm after wrap");
    // R5 periodic with slow prescale
    wr(5'h00, 0);
    wr(5'h04, 4);
    tick(3);
    rd(5'h08, 0, "R5 before period");
    tick(1);
    rd(5'h08, 32'h1, "R5 period hit");
    tick(8);
    rd(5'h08, 32'h1, "R5 sticky repeat");
    wr(5'h04, 0);
    tick(10);
    rd(5'h08, 0, "R5 disabled");
    rd(5'h04, 0, "R5 period readback");
    // R7 watchdog flag
    wd_ovf_set = 1; @(negedge clk); wd_ovf_set = 0;
    rd(5'h08, 32'h2, "R7 watchdog flag");
    // R9 mask
    wr(5'h0C, 32'h9);
    rd(5'h14, 32'h9, "R9 enable set");
    wr(5'h0C, 0);
    rd(5'h14, 32'h9, "R9 zero enable no effect");
    wr(5'h10, 32'h1);
    rd(5'h14, 32'h8, "R9 disable clear");
    chk_irq(1'b0, "R10 no flags");
    // R10 irq
    wd_ovf_set = 1; @(negedge clk); wd_ovf_set = 0;
    chk_irq(1'b0, "R10 flag masked");
    wr(5'h0C, 32'h2);
    chk_irq(1'b1, "R10 flag enabled");
    rd(5'h08, 32'h2, "R10 status");
    chk_irq(1'b0, "R10 cleared");
    // R8 set during read stays pending
    wd_ovf_set = 1;
    rd(5'h08, 0, "R8 same cycle read value");
    wd_ovf_set = 0;
    chk_irq(1'b1, "R8 pending after read");
    rd(5'h08, 32'h2, "R8 pending flag");
    // R11 read-only registers
    wr(5'h1C, 123);
    wr(5'h14, 32'hF);
    rd(5'h1C, 11, "R11 counter write ignored");
    rd(5'h14, 32'hA, "R11 mask write ignored");
    // R12 no ticks
    wr(5'h00, 1);
    repeat (50) @(negedge clk);
    rd(5'h1C, 11, "R12 counter held");
    rd(5'h08, 0, "R12 no events");
    repeat (3) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL missing responses actual %0d expected 0", sb.size());
    end
    finish_run();
  end
endmodule